// File: doc/BRIEF.md
# Loop Requeue Stage Controller

This block sits in front of a dock's circular instruction FIFO and decides which of two instruction streams feeds it. The loading stream carries freshly dispatched instructions. The recycle stream carries instructions that have already gone through execution and come back around. A two-mode controller chooses, on every cycle, whether each stream is forwarded, dropped or held. It uses loop-start (head) and loop-end (tail) marker words to make that choice.

In loading mode, the block drains the old loop and refills the FIFO. Non-tail words on the loading stream go to the output, and non-head words on the recycle stream are consumed and thrown away. A tail stalls on the loading stream and a head stalls on the recycle stream. When both are stalled at once, both markers are consumed and the block switches to looping mode. In looping mode, the loading stream is shut and every recycled word is passed straight back into the FIFO. An executed abort strobe from the execution side ends the loop and returns the block to loading mode.

Top module: `loop_requeue`

## Requirements
- R1: After reset the block is in loading mode: a non-tail word on the loading stream is offered at the output.
- R2: In loading mode, a loading-stream word whose bits [20:17] are not 1111 appears on the output unchanged, with out_valid high and ld_ready equal to out_ready.
- R3: In loading mode, a recycle-stream word whose bits [20:17] are not 1110 is consumed (rc_ready high) and never reaches the output.
- R4: In loading mode, a tail (bits [20:17] = 1111) on the loading stream is held (ld_ready low) unless a head is present on the recycle stream. A head (bits [20:17] = 1110) on the recycle stream is held (rc_ready low) unless a tail is present on the loading stream.
- R5: In loading mode, when a tail on the loading stream and a head on the recycle stream are valid together and no abort is strobed, both ready signals are high, the output stays invalid, and the block is in looping mode from the next cycle.
- R6: In looping mode, ld_ready is low, out_valid equals rc_valid, out_data equals rc_data, and rc_ready equals out_ready, whatever the marker bits of the word.
- R7: An abort strobe in looping mode puts the block in loading mode from the next cycle.
- R8: An abort strobe in loading mode does not change the mode. If it coincides with a tail/head pairing, the pairing is deferred and both markers stay held that cycle.
- R9: out_valid is high only while one input word is being forwarded. In loading mode with no non-tail loading word, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Loading-stream word valid |
| ld_ready | output | 1 | Loading-stream word accepted |
| ld_data | input | 26 | Loading-stream instruction word |
| rc_valid | input | 1 | Recycle-stream word valid |
| rc_ready | output | 1 | Recycle-stream word consumed |
| rc_data | input | 26 | Recycle-stream instruction word |
| out_valid | output | 1 | Word offered to the FIFO |
| out_ready | input | 1 | FIFO can take the word |
| out_data | output | 26 | Word written to the FIFO |
| abort_exec | input | 1 | An abort instruction executed with its predicate met |

## Verification
The hardest situation to reach from the ports is the exact cycle in which a tail stalls on the loading stream while a head stalls on the recycle stream. Random words seldom carry the right marker bits on both sides at once. A pairing that coincides with an abort strobe is rarer still. The stimulus biases the marker field of random words heavily toward head and tail codes and strobes aborts at a modest rate. Directed sequences place a tail alone, a head alone, a pairing with abort, and a clean pairing followed by looping traffic and an abort.

// File: rtl/rq_pkg.sv
package rq_pkg;
    localparam int INSTR_W  = 26;
    localparam int OP_LO    = 17;
    localparam int OP_W     = 4;
    localparam int OP_HI    = OP_LO + OP_W - 1;
    localparam logic [OP_W-1:0] HEAD_OP = 4'b1110;
    localparam logic [OP_W-1:0] TAIL_OP = 4'b1111;

    typedef enum logic {
        MODE_LOAD = 1'b0,
        MODE_LOOP = 1'b1
    } rq_mode_e;

    typedef enum logic [1:0] {
        K_OTHER = 2'd0,
        K_HEAD  = 2'd1,
        K_TAIL  = 2'd2
    } rq_kind_e;

    function automatic rq_kind_e classify(input logic [OP_W-1:0] op);
        if (op == HEAD_OP)      return K_HEAD;
        else if (op == TAIL_OP) return K_TAIL;
        else                    return K_OTHER;
    endfunction
endpackage

// File: rtl/rq_classify.sv
module rq_classify
    import rq_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output rq_kind_e        kind
);
    always_comb kind = classify(op);
endmodule

// File: rtl/rq_mode_fsm.sv
module rq_mode_fsm
    import rq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pair_fire,
    input  logic     abort_exec,
    output rq_mode_e mode
);
    rq_mode_e mode_nx;

    always_comb begin
        mode_nx = mode;
        unique case (mode)
            MODE_LOAD: if (pair_fire)  mode_nx = MODE_LOOP;
            MODE_LOOP: if (abort_exec) mode_nx = MODE_LOAD;
            default:                   mode_nx = MODE_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode <= MODE_LOAD;
        else     mode <= mode_nx;
    end

    // R7: abort in looping mode ends the loop on the next cycle
    p_abort_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOOP && abort_exec) |=> (mode == MODE_LOAD));

    // R5: a completed pairing enters looping mode
    p_pair_enter_r5: assert property (@(posedge clk) disable iff (rst)
        pair_fire |=> (mode == MODE_LOOP));

    // R8: abort while loading never flips the mode
    p_abort_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOAD && abort_exec) |=> (mode == MODE_LOAD));
endmodule

// File: rtl/rq_steer.sv
module rq_steer
    import rq_pkg::*;
#(
    parameter int W = INSTR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  rq_mode_e     mode,
    input  logic         ld_valid,
    input  rq_kind_e     ld_kind,
    input  logic [W-1:0] ld_data,
    input  logic         rc_valid,
    input  rq_kind_e     rc_kind,
    input  logic [W-1:0] rc_data,
    input  logic         out_ready,
    input  logic         abort_exec,
    output logic         ld_ready,
    output logic         rc_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         pair_fire
);
    logic tail_wait, head_wait;

    always_comb begin
        tail_wait = ld_valid && (ld_kind == K_TAIL);
        head_wait = rc_valid && (rc_kind == K_HEAD);
        pair_fire = 1'b0;
        ld_ready  = 1'b0;
        rc_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = ld_data;
        if (mode == MODE_LOOP) begin
            out_valid = rc_valid;
            out_data  = rc_data;
            rc_ready  = out_ready;
        end else begin
            pair_fire = tail_wait && head_wait && !abort_exec;
            if (pair_fire) begin
                ld_ready = 1'b1;
                rc_ready = 1'b1;
            end else begin
                if (ld_valid && ld_kind != K_TAIL) begin
                    out_valid = 1'b1;
                    ld_ready  = out_ready;
                end
                if (rc_valid && rc_kind != K_HEAD)
                    rc_ready = 1'b1;
            end
        end
    end

    // R6: loading stream shut while looping
    p_ld_shut_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOOP) |-> !ld_ready);

    // R4: a lone tail stays stalled
    p_tail_held_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOAD && tail_wait && !head_wait) |-> !ld_ready);

    // R9: output only when some input is offering a word
    p_out_source_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (ld_valid || rc_valid));

    // R5: a pairing never produces an output word
    p_pair_silent_r5: assert property (@(posedge clk) disable iff (rst)
        pair_fire |-> !out_valid);
endmodule

// File: rtl/loop_requeue.sv
module loop_requeue
    import rq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_valid,
    output logic               ld_ready,
    input  logic [INSTR_W-1:0] ld_data,
    input  logic               rc_valid,
    output logic               rc_ready,
    input  logic [INSTR_W-1:0] rc_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [INSTR_W-1:0] out_data,
    input  logic               abort_exec
);
    localparam int NSRC = 2;

    logic [OP_W-1:0] src_op   [NSRC];
    rq_kind_e        src_kind [NSRC];
    rq_mode_e        mode;
    logic            pair_fire;

    assign src_op[0] = ld_data[OP_HI:OP_LO];
    assign src_op[1] = rc_data[OP_HI:OP_LO];

    for (genvar i = 0; i < NSRC; i++) begin : g_cls
        rq_classify u_cls (.op(src_op[i]), .kind(src_kind[i]));
    end

    rq_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .pair_fire(pair_fire),
        .abort_exec(abort_exec), .mode(mode)
    );

    rq_steer #(.W(INSTR_W)) u_steer (
        .clk(clk), .rst(rst), .mode(mode),
        .ld_valid(ld_valid), .ld_kind(src_kind[0]), .ld_data(ld_data),
        .rc_valid(rc_valid), .rc_kind(src_kind[1]), .rc_data(rc_data),
        .out_ready(out_ready), .abort_exec(abort_exec),
        .ld_ready(ld_ready), .rc_ready(rc_ready),
        .out_valid(out_valid), .out_data(out_data), .pair_fire(pair_fire)
    );
endmodule

// File: tb/tb_loop_requeue.sv
`timescale 1ns/1ps
module tb_loop_requeue;
    localparam int W = 26;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ld_valid = 0, rc_valid = 0, out_ready = 0, abort_exec = 0;
    logic [W-1:0] ld_data = '0, rc_data = '0;
    logic ld_ready, rc_ready, out_valid;
    logic [W-1:0] out_data;

    int errors = 0, checks = 0;
    bit m_loop = 0;   // bench's own mode model
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    loop_requeue dut (
        .clk(clk), .rst(rst),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
        .rc_valid(rc_valid), .rc_ready(rc_ready), .rc_data(rc_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .abort_exec(abort_exec)
    );

    // kind: 0 other, 1 head (1110), 2 tail (1111)
    function automatic logic [W-1:0] mk(int kind);
        logic [W-1:0] w = W'($urandom);
        logic [3:0] op;
        if (kind == 1)      op = 4'b1110;
        else if (kind == 2) op = 4'b1111;
        else begin
            op = 4'($urandom_range(0, 13));
        end
        w[20:17] = op;
        return w;
    endfunction

    function automatic bit is_tail(logic [W-1:0] w); return w[20:17] == 4'b1111; endfunction
    function automatic bit is_head(logic [W-1:0] w); return w[20:17] == 4'b1110; endfunction

    task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive after negedge, check combinational outputs, then update model at posedge
    task automatic cyc(bit lv, logic [W-1:0] ld, bit rv, logic [W-1:0] rd,
                       bit ordy, bit ab, string force_tag);
        bit pair, fire, e_ov, e_lr, e_rr;
        logic [W-1:0] e_od;
        string tl, tr, to;
        @(negedge clk);
        ld_valid = lv; ld_data = ld; rc_valid = rv; rc_data = rd;
        out_ready = ordy; abort_exec = ab;
        #5;
        pair = lv && is_tail(ld) && rv && is_head(rd);
        fire = 0;
        if (m_loop) begin
            e_lr = 0; e_rr = ordy; e_ov = rv; e_od = rd;
            tl = "R6"; tr = "R6"; to = "R6";
        end else begin
            fire = pair && !ab;
            e_ov = !fire && lv && !is_tail(ld);
            e_od = ld;
            e_lr = fire ? 1'b1 : (e_ov ? ordy : 1'b0);
            e_rr = fire ? 1'b1 : (rv && !is_head(rd));
            tl = is_tail(ld) ? (pair ? (ab ? "R8" : "R5") : "R4") : "R2";
            tr = is_head(rd) ? (pair ? (ab ? "R8" : "R5") : "R4") : "R3";
            to = e_ov ? "R2" : "R9";
        end
        if (force_tag != "") begin tl = force_tag; tr = force_tag; to = force_tag; end
        chk(to, "out_valid", W'(out_valid), W'(e_ov));
        if (e_ov) chk(to, "out_data", out_data, e_od);
        if (lv || m_loop) chk(tl, "ld_ready", W'(ld_ready), W'(e_lr));
        if (rv) chk(tr, "rc_ready", W'(rc_ready), W'(e_rr));
        @(posedge clk);
        if (!m_loop && fire) m_loop = 1;
        else if (m_loop && ab) m_loop = 0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state is loading mode
        cyc(1, mk(0), 0, '0, 1, 0, "R1");
        // R4: lone tail held, lone head held
        cyc(1, mk(2), 0, '0, 1, 0, "R4");
        cyc(0, '0, 1, mk(1), 1, 0, "R4");
        // R3: recycled non-head dropped while new word forwarded under backpressure
        cyc(1, mk(0), 1, mk(0), 0, 0, "");
        // R8: pairing with abort deferred
        cyc(1, mk(2), 1, mk(1), 1, 1, "R8");
        cyc(1, mk(0), 0, '0, 1, 0, "R8");   // still loading
        // R5: clean pairing
        cyc(1, mk(2), 1, mk(1), 1, 0, "R5");
        // R6: looping passes heads and tails too
        cyc(1, mk(0), 1, mk(1), 1, 0, "R6");
        cyc(1, mk(2), 1, mk(2), 0, 0, "R6");
        cyc(0, '0, 0, '0, 1, 0, "R6");
        // R7: abort returns to loading
        cyc(0, '0, 1, mk(0), 1, 1, "R6");
        cyc(1, mk(0), 0, '0, 1, 0, "R7");
        // R9: idle loading gives no output
        cyc(0, '0, 0, '0, 1, 0, "R9");

        for (int i = 0; i < 3000; i++) begin
            int kl = ($urandom_range(0, 9) < 4) ? 2 : 0;
            int kr = ($urandom_range(0, 9) < 4) ? 1 : 0;
            cyc(bit'($urandom_range(0, 3) != 0), mk(kl),
                bit'($urandom_range(0, 3) != 0), mk(kr),
                bit'($urandom_range(0, 3) != 0),
                bit'($urandom_range(0, 19) == 0), "");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule